// File: doc/BRIEF.md
# DRAM Sub-Sequence Command Issuer

This block executes one queued memory-test command on a DRAM command bus. A sequencer loads the command's configuration and pulses `start`. The block then puts the command on the bus a programmed number of times. It inserts a programmed number of deselect cycles between consecutive issues, and a programmed number of trailing idle cycles after the last issue. It then raises a one-cycle `finished` pulse for the sequencer.

In each issue cycle the block does the following:
- It drives the active-low RAS, CAS and WE lines from a 3-bit command word.
- It drives the per-rank CKE and ODT lines from their control fields.
- It drives the per-rank chip selects. These come either straight from a control field or masked by the decoded rank select, which an address generator supplies.
- It raises `run_done`, which tells the address generator that one run of the command has completed.
- It presents a data-direction tag.

The controller is a five-state machine:
- **IDLE** leaves on `start` (*launch*) to **ISSUE**.
- **ISSUE** goes to **ISSUE** again when more repetitions remain and the gap is zero (*back-to-back*).
- **ISSUE** goes to **GAP** when more repetitions remain and the gap is non-zero (*space*).
- **ISSUE** goes to **TAIL** after the last repetition when the idle count is non-zero (*drain*).
- **ISSUE** goes to **DONE** after the last repetition when the idle count is zero (*close*).
- **GAP** returns to **ISSUE** when its count runs out (*resume*).
- **TAIL** moves to **DONE** when its count runs out (*close*).
- **DONE** always returns to **IDLE** (*retire*).

Top module: `dram_subseq_issuer`

## Requirements
- R1: After reset the bus is in deselect: `cs_n` = 4'b1111, `ras_n`/`cas_n`/`we_n` = 1, `cke` = `odt` = 0, and `run_done`, `finished`, `auto_pre` = 0, `dir_tag` = 2'b00.
- R2: In an issue cycle, the command word and per-rank fields latched at launch drive the bus: `ras_n` = bit 0, `cas_n` = bit 1, `we_n` = bit 2, `cke` = `cfg_cke`, `odt` = `cfg_odt`. `cke`/`odt` hold their latched values between issues.
- R3: In an issue cycle with chip-select mode 0, `cs_n` equals the latched `cfg_cs_ctl` unchanged.
- R4: In an issue cycle with chip-select mode 1, `rank_sel` (2 bits) is decoded one-hot (`dec` = 1 << `rank_sel`), and `cs_n[i]` = ~`dec[i]` & `cs_ctl[i]`.
- R5: The command is issued N = `cfg_reps` times. A value of 0 means one issue. `run_done` is high in exactly the N issue cycles.
- R6: Between consecutive issues there are exactly `cfg_gap` cycles, so issue k (from 0) falls k·(`cfg_gap`+1) cycles after the first.
- R7: After the last issue come exactly `cfg_idle` deselect cycles, then `finished` is high for one cycle. The next `start` is accepted in the cycle after that.
- R8: In every cycle that is not an issue cycle, `cs_n` = 4'b1111, `ras_n`/`cas_n`/`we_n` = 1, and `dir_tag` = 2'b00.
- R9: In an issue cycle `dir_tag` carries the latched direction: 00 none, 01 read, 10 write, 11 read and write.
- R10: `auto_pre` is high in an issue cycle only when `cfg_ap` = 1 and the row-width code `cfg_row_code` = 0 (valid row bits = 10 + code). Otherwise it is 0.
- R11: `start` and all configuration inputs are ignored from launch until the cycle after `finished`. This includes the cycle in which `finished` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken only in IDLE |
| cfg_cmd | input | 3 | Command word: bit0 RAS_n, bit1 CAS_n, bit2 WE_n |
| cfg_cke | input | 4 | CKE value per rank |
| cfg_odt | input | 4 | ODT value per rank |
| cfg_cs_mode | input | 1 | 1 = mask chip selects with decoded rank select |
| cfg_cs_ctl | input | 4 | Chip-select control per rank |
| cfg_ap | input | 1 | Auto-precharge request |
| cfg_row_code | input | 3 | Row-width code, valid row bits = 10 + code |
| cfg_reps | input | 9 | Repetition count, 0 treated as 1 |
| cfg_gap | input | 5 | Deselect cycles between issues |
| cfg_idle | input | 9 | Deselect cycles after the last issue |
| cfg_dir | input | 2 | Data-direction tag |
| rank_sel | input | 2 | Rank select from the address generator |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 4 | Clock enable per rank |
| odt | output | 4 | On-die termination per rank |
| cs_n | output | 4 | Chip selects per rank |
| auto_pre | output | 1 | Auto-precharge flag with the command |
| dir_tag | output | 2 | Data direction of the issued command |
| run_done | output | 1 | One command run completed (issue cycle) |
| finished | output | 1 | One-cycle end-of-command pulse |

## Verification
Two events can land in the same cycle: a new launch request and the block's own completion. A `start` can arrive, with fresh configuration values, while a run is in progress. The sharpest case is the cycle in which `finished` is high, because the next cycle is IDLE and a premature acceptance would be hard to see. The bench holds `start` high with randomised configuration throughout chosen runs, including that final cycle. It then checks that the issue timing, bus values, `finished` placement and the return to an idle bus all still match the configuration captured at launch.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GAP,
        ST_TAIL,
        ST_DONE
    } sseq_state_e;

    localparam logic [1:0] DIR_NONE = 2'b00;

endpackage

// File: rtl/sseq_csgen.sv
module sseq_csgen #(
    parameter int NRANK = 4
) (
    input  logic                                   issue,
    input  logic                                   mode,
    input  logic [NRANK-1:0]                       cs_ctl,
    input  logic [((NRANK > 1) ? $clog2(NRANK) : 1)-1:0] rank_sel,
    output logic [NRANK-1:0]                       cs_n
);
    localparam int RSEL_W = (NRANK > 1) ? $clog2(NRANK) : 1;

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        logic hit;
        assign hit     = (rank_sel == RSEL_W'(r));
        assign cs_n[r] = issue ? (mode ? (~hit & cs_ctl[r]) : cs_ctl[r]) : 1'b1;
    end

endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
    import sseq_pkg::*;
#(
    parameter int REP_W  = 9,
    parameter int GAP_W  = 5,
    parameter int IDLE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [REP_W-1:0]  reps,
    input  logic [GAP_W-1:0]  gap,
    input  logic [IDLE_W-1:0] idle,
    output logic              busy,
    output logic              issue,
    output logic              done
);
    localparam int CNT_W = (GAP_W > IDLE_W) ? GAP_W : IDLE_W;

    sseq_state_e      st_q, st_d;
    logic [REP_W-1:0] rep_q, rep_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            rep_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            rep_q <= rep_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        rep_d = rep_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (launch) begin
                    st_d  = ST_ISSUE;
                    rep_d = (reps == '0) ? '0 : reps - REP_W'(1);
                end
            end
            ST_ISSUE: begin
                if (rep_q != '0) begin
                    if (gap != '0) begin
                        st_d  = ST_GAP;
                        cnt_d = CNT_W'(gap) - CNT_W'(1);
                    end else begin
                        st_d  = ST_ISSUE;
                        rep_d = rep_q - REP_W'(1);
                    end
                end else if (idle != '0) begin
                    st_d  = ST_TAIL;
                    cnt_d = CNT_W'(idle) - CNT_W'(1);
                end else begin
                    st_d = ST_DONE;
                end
            end
            ST_GAP: begin
                if (cnt_q == '0) begin
                    st_d  = ST_ISSUE;
                    rep_d = rep_q - REP_W'(1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_TAIL: begin
                if (cnt_q == '0) st_d = ST_DONE;
                else             cnt_d = cnt_q - CNT_W'(1);
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign busy  = (st_q != ST_IDLE);
    assign issue = (st_q == ST_ISSUE);
    assign done  = (st_q == ST_DONE);

    // R6
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> (cnt_q < CNT_W'(gap)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R5
    last_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && rep_q == '0) |=> (st_q == ST_TAIL || st_q == ST_DONE));

endmodule

// File: rtl/dram_subseq_issuer.sv
module dram_subseq_issuer
    import sseq_pkg::*;
#(
    parameter int NRANK  = 4,
    parameter int REP_W  = 9,
    parameter int GAP_W  = 5,
    parameter int IDLE_W = 9,
    parameter int ROWC_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            cfg_cmd,
    input  logic [NRANK-1:0]      cfg_cke,
    input  logic [NRANK-1:0]      cfg_odt,
    input  logic                  cfg_cs_mode,
    input  logic [NRANK-1:0]      cfg_cs_ctl,
    input  logic                  cfg_ap,
    input  logic [ROWC_W-1:0]     cfg_row_code,
    input  logic [REP_W-1:0]      cfg_reps,
    input  logic [GAP_W-1:0]      cfg_gap,
    input  logic [IDLE_W-1:0]     cfg_idle,
    input  logic [1:0]            cfg_dir,
    input  logic [((NRANK > 1) ? $clog2(NRANK) : 1)-1:0] rank_sel,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic [NRANK-1:0]      cke,
    output logic [NRANK-1:0]      odt,
    output logic [NRANK-1:0]      cs_n,
    output logic                  auto_pre,
    output logic [1:0]            dir_tag,
    output logic                  run_done,
    output logic                  finished
);
    logic [2:0]        cmd_q;
    logic [NRANK-1:0]  cke_q, odt_q, csctl_q;
    logic              mode_q, ap_q;
    logic [ROWC_W-1:0] row_q;
    logic [GAP_W-1:0]  gap_q;
    logic [IDLE_W-1:0] idle_q;
    logic [1:0]        dir_q;
    logic              busy, issue, done, launch;

    assign launch = start && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= 3'b111;
            cke_q   <= '0;
            odt_q   <= '0;
            csctl_q <= '1;
            mode_q  <= 1'b0;
            ap_q    <= 1'b0;
            row_q   <= '0;
            gap_q   <= '0;
            idle_q  <= '0;
            dir_q   <= DIR_NONE;
        end else if (launch) begin
            cmd_q   <= cfg_cmd;
            cke_q   <= cfg_cke;
            odt_q   <= cfg_odt;
            csctl_q <= cfg_cs_ctl;
            mode_q  <= cfg_cs_mode;
            ap_q    <= cfg_ap;
            row_q   <= cfg_row_code;
            gap_q   <= cfg_gap;
            idle_q  <= cfg_idle;
            dir_q   <= cfg_dir;
        end
    end

    sseq_fsm #(
        .REP_W (REP_W),
        .GAP_W (GAP_W),
        .IDLE_W(IDLE_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .launch(launch),
        .reps  (cfg_reps),
        .gap   (gap_q),
        .idle  (idle_q),
        .busy  (busy),
        .issue (issue),
        .done  (done)
    );

    sseq_csgen #(.NRANK(NRANK)) u_cs (
        .issue   (issue),
        .mode    (mode_q),
        .cs_ctl  (csctl_q),
        .rank_sel(rank_sel),
        .cs_n    (cs_n)
    );

    always_comb begin
        ras_n    = issue ? cmd_q[0] : 1'b1;
        cas_n    = issue ? cmd_q[1] : 1'b1;
        we_n     = issue ? cmd_q[2] : 1'b1;
        cke      = cke_q;
        odt      = odt_q;
        auto_pre = issue && ap_q && (row_q == '0);
        dir_tag  = issue ? dir_q : DIR_NONE;
        run_done = issue;
        finished = done;
    end

    // R8
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_done |-> ((&cs_n) && ras_n && cas_n && we_n && dir_tag == DIR_NONE));

    // R4
    rank_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && mode_q) |-> !cs_n[rank_sel]);

    // R10
    autopre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (run_done && row_q == '0));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({cmd_q, cke_q, odt_q, csctl_q, mode_q, ap_q, row_q, gap_q, idle_q, dir_q}));

endmodule

// File: tb/tb_dram_subseq_issuer.sv
module tb_dram_subseq_issuer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cfg_cmd = '0;
    logic [3:0] cfg_cke = '0, cfg_odt = '0, cfg_cs_ctl = '0;
    logic       cfg_cs_mode = 1'b0, cfg_ap = 1'b0;
    logic [2:0] cfg_row_code = '0;
    logic [8:0] cfg_reps = '0;
    logic [4:0] cfg_gap = '0;
    logic [8:0] cfg_idle = '0;
    logic [1:0] cfg_dir = '0;
    logic [1:0] rank_sel = '0;

    logic       ras_n, cas_n, we_n, auto_pre, run_done, finished;
    logic [3:0] cke, odt, cs_n;
    logic [1:0] dir_tag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_subseq_issuer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_cmd(cfg_cmd), .cfg_cke(cfg_cke),
        .cfg_odt(cfg_odt), .cfg_cs_mode(cfg_cs_mode), .cfg_cs_ctl(cfg_cs_ctl), .cfg_ap(cfg_ap),
        .cfg_row_code(cfg_row_code), .cfg_reps(cfg_reps), .cfg_gap(cfg_gap), .cfg_idle(cfg_idle),
        .cfg_dir(cfg_dir), .rank_sel(rank_sel), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .odt(odt), .cs_n(cs_n), .auto_pre(auto_pre), .dir_tag(dir_tag),
        .run_done(run_done), .finished(finished)
    );

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [3:0] exp_cs(bit iss, bit mode, logic [3:0] ctl, logic [1:0] rs);
        logic [3:0] dec;
        if (!iss) return 4'hF;
        dec = 4'b0001 << rs;
        return mode ? (~dec & ctl) : ctl;
    endfunction

    task automatic run_cmd(logic [2:0] cmd, logic [3:0] ck, logic [3:0] od, bit mode,
                           logic [3:0] ctl, bit ap, logic [2:0] row, int reps, int gap,
                           int idle, logic [1:0] dir, logic [1:0] rs, bit interf);
        int n, t_end, n_issue_cycles;
        bit iss, fin;
        cfg_cmd = cmd; cfg_cke = ck; cfg_odt = od; cfg_cs_mode = mode; cfg_cs_ctl = ctl;
        cfg_ap = ap; cfg_row_code = row; cfg_reps = 9'(reps); cfg_gap = 5'(gap);
        cfg_idle = 9'(idle); cfg_dir = dir; rank_sel = rs; start = 1'b1;
        n = (reps == 0) ? 1 : reps;
        n_issue_cycles = n + (n - 1) * gap;
        t_end = n_issue_cycles + idle + 1;
        @(negedge clk);
        for (int k = 0; k <= t_end; k++) begin
            iss = (k < n_issue_cycles) && ((k % (gap + 1)) == 0);
            fin = (k == t_end - 1);
            chk(interf ? "R11" : "R5/R6", "run_done", 32'(run_done), 32'(iss));
            chk(iss ? (mode ? "R4" : "R3") : "R8", "cs_n", 32'(cs_n), 32'(exp_cs(iss, mode, ctl, rs)));
            chk(iss ? "R2" : "R8", "ras/cas/we", 32'({we_n, cas_n, ras_n}), 32'(iss ? cmd : 3'b111));
            chk("R2", "cke/odt", 32'({cke, odt}), 32'({ck, od}));
            chk(iss ? "R9" : "R8", "dir_tag", 32'(dir_tag), 32'(iss ? dir : 2'b00));
            chk("R10", "auto_pre", 32'(auto_pre), 32'(iss && ap && row == 3'd0));
            chk("R7", "finished", 32'(finished), 32'(fin));
            if (k < t_end && interf) begin
                start = 1'b1;
                cfg_cmd = 3'($urandom); cfg_cke = 4'($urandom); cfg_odt = 4'($urandom);
                cfg_cs_mode = 1'($urandom); cfg_cs_ctl = 4'($urandom); cfg_ap = 1'b1;
                cfg_row_code = 3'($urandom); cfg_reps = 9'($urandom);
                cfg_gap = 5'($urandom); cfg_idle = 9'($urandom); cfg_dir = 2'($urandom);
            end else begin
                start = 1'b0;
            end
            if (k < t_end) @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0017);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cs_n", 32'(cs_n), 32'hF);
        chk("R1", "ras/cas/we", 32'({we_n, cas_n, ras_n}), 32'h7);
        chk("R1", "cke/odt", 32'({cke, odt}), 32'h0);
        chk("R1", "strobes", 32'({run_done, finished, auto_pre, dir_tag}), 32'h0);

        // Directed corners
        run_cmd(3'b010, 4'hF, 4'h3, 1'b0, 4'h5, 1'b1, 3'd0, 0, 3, 0, 2'b01, 2'd0, 1'b0); // R5 reps=0, R10 on
        run_cmd(3'b100, 4'h1, 4'h8, 1'b1, 4'hF, 1'b1, 3'd3, 4, 0, 0, 2'b10, 2'd2, 1'b0); // R6 gap=0, R10 off
        for (int r = 0; r < 4; r++)
            run_cmd(3'b001, 4'hA, 4'h5, 1'b1, 4'hF, 1'b0, 3'd1, 2, 1, 2, 2'b11, 2'(r), 1'b0); // R4 each rank
        run_cmd(3'b110, 4'h6, 4'h9, 1'b1, 4'h6, 1'b0, 3'd0, 3, 31, 511, 2'b00, 2'd1, 1'b0); // R6/R7 maxima
        run_cmd(3'b011, 4'hC, 4'h0, 1'b0, 4'h9, 1'b1, 3'd0, 300, 2, 5, 2'b01, 2'd3, 1'b0); // R5 long
        run_cmd(3'b000, 4'h3, 4'hC, 1'b1, 4'hB, 1'b1, 3'd0, 3, 2, 4, 2'b10, 2'd1, 1'b1);  // R11
        run_cmd(3'b101, 4'h2, 4'h4, 1'b0, 4'h7, 1'b0, 3'd2, 1, 0, 0, 2'b11, 2'd0, 1'b1);  // R11 shortest

        // Constrained random mix
        for (int i = 0; i < 60; i++) begin
            run_cmd(3'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
                    1'($urandom), 3'($urandom_range(0, 2)), int'($urandom_range(0, 6)),
                    int'($urandom_range(0, 7)), int'($urandom_range(0, 15)), 2'($urandom),
                    2'($urandom), ($urandom_range(0, 3) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule